// File: doc/BRIEF.md
# Audio Channel Byte FIFO with Word Framing

This block sits between a DMA engine and an audio peripheral and buffers one channel's data. Bytes arrive one at a time on the memory side. The peripheral side receives one sample word at a time, with the sample bytes packed little-endian. A two-bit slot number comes with each word and gives the word's position inside an audio frame. The peripheral uses this slot number as sideband framing.

Two configuration words control the block. A format byte selects the sample width (8, 16 or 32 bits) and the frame length (1, 2 or 4 words). A FIFO control word gives a byte limit and a byte threshold. The memory side is stalled so that the occupancy never rises above the limit. A transfer request stays high while the occupancy is at or below the threshold, which tells the DMA engine to fetch more data.

The slot number comes from a four-state machine with the states SLOT0, SLOT1, SLOT2 and SLOT3. Reset enters SLOT0. The state moves only when a word is accepted at the output:
- SLOT0 → SLOT1, or SLOT0 → SLOT0 when the frame is one word long.
- SLOT1 → SLOT2, or SLOT1 → SLOT0 when the frame is two words long.
- SLOT2 → SLOT3, or SLOT2 → SLOT0 when the frame ends there.
- SLOT3 → SLOT0 always.

Top module: `aud_chan_framer`

## Requirements
- R1: After reset, `out_valid` is low, `out_slot` is 0, `xfer_req` is high, and `in_ready` is high whenever the configured limit is nonzero.
- R2: `cfg_fmt[3:0]` selects the word size: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. The first byte received sits in `out_word[7:0]`, and bits above the word size read as zero.
- R3: `cfg_fmt[7:4]` selects the frame length: 0 gives 1 word, 1 gives 2 words, 2 gives 4 words. `out_slot` steps by one on each accepted output word and wraps to 0 after the last word of the frame. `out_slot` holds its value when no word is accepted.
- R4: Word-size codes above 2 act as 4 bytes, and frame-length codes above 2 act as a one-word frame.
- R5: `cfg_fifo[31:16]` is a byte limit, capped at DEPTH. `in_ready` is low while the occupancy is at or above the limit, and a byte offered during a stall is not taken.
- R6: `xfer_req` is high exactly when the occupancy in bytes is at or below `cfg_fifo[15:0]`.
- R7: `out_valid` is high when at least one word's worth of bytes is stored. Bytes leave in the order they arrived, with none lost and none duplicated.
- R8: While `out_valid` is high and `out_ready` is low, the word stays valid and unchanged.
- R9: A byte push and a word pop in the same cycle are both honoured, so an uninterrupted stream passes without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 8 | [3:0] word size code, [7:4] frame length code |
| cfg_fifo | input | 32 | [31:16] byte limit, [15:0] request threshold in bytes |
| in_valid | input | 1 | Memory-side byte offered |
| in_ready | output | 1 | Memory-side byte can be taken |
| in_byte | input | 8 | Memory-side byte |
| out_valid | output | 1 | Peripheral-side word available |
| out_ready | input | 1 | Peripheral accepts the word |
| out_word | output | 32 | Packed sample word, zero-extended |
| out_slot | output | 2 | Word position within the frame |
| xfer_req | output | 1 | Request for more memory data |

## Verification
The bench uses the default DEPTH of 256 bytes. Limits and thresholds of only a few bytes are set through `cfg_fifo`, so the stall and request edges are reached within a dozen cycles. The bench runs every word size and every frame length, including reserved codes, under three consumer patterns: always ready, ready on alternate cycles, and never ready. The alternating pattern makes pushes and pops fall in the same cycle and exercises the hold behaviour. Reaching the DEPTH cap itself would need a limit of more than 256 bytes, and the bench does not use such a limit.

// File: rtl/aud_fmt_pkg.sv
package aud_fmt_pkg;

    typedef enum logic [1:0] {
        SLOT0 = 2'd0,
        SLOT1 = 2'd1,
        SLOT2 = 2'd2,
        SLOT3 = 2'd3
    } slot_e;

    // bytes per sample word; reserved codes fall back to 4
    function automatic logic [2:0] word_bytes(input logic [3:0] code);
        case (code)
            4'd0:    word_bytes = 3'd1;
            4'd1:    word_bytes = 3'd2;
            default: word_bytes = 3'd4;
        endcase
    endfunction

    // index of the final slot of a frame; reserved codes fall back to 0
    function automatic logic [1:0] frame_last(input logic [3:0] code);
        case (code)
            4'd1:    frame_last = 2'd1;
            4'd2:    frame_last = 2'd3;
            default: frame_last = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/aud_fmt_decode.sv
module aud_fmt_decode
    import aud_fmt_pkg::*;
(
    input  logic [7:0] fmt,
    output logic [2:0] wbytes,
    output logic [1:0] last_slot
);

    always_comb begin
        wbytes    = word_bytes(fmt[3:0]);
        last_slot = frame_last(fmt[7:4]);
    end

endmodule

// File: rtl/aud_byte_store.sv
module aud_byte_store #(
    parameter int DEPTH = 256,
    parameter int TAPS  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [7:0]         push_byte,
    input  logic               pop,
    input  logic [2:0]         pop_n,
    output logic [TAPS*8-1:0]  head,
    output logic [CNT_W-1:0]   occ
);

    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occ_q;
    logic [CNT_W-1:0] pop_cnt;

    assign pop_cnt = pop ? CNT_W'(pop_n) : '0;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + PTR_W'(pop_n);
            end
            occ_q <= occ_q + CNT_W'(push) - pop_cnt;
        end
    end

    // read taps at the head; pointer arithmetic wraps since DEPTH is a power of two
    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        assign head[8*j +: 8] = mem[rd_ptr + PTR_W'(j)];
    end

    assign occ = occ_q;

endmodule

// File: rtl/aud_frame_fsm.sv
module aud_frame_fsm
    import aud_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [1:0] last_slot,
    output logic [1:0] slot
);

    slot_e st_q;
    slot_e st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SLOT0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        if (adv) begin
            unique case (st_q)
                SLOT0: st_d = (last_slot == 2'd0) ? SLOT0 : SLOT1;
                SLOT1: st_d = (last_slot <= 2'd1) ? SLOT0 : SLOT2;
                SLOT2: st_d = (last_slot <= 2'd2) ? SLOT0 : SLOT3;
                SLOT3: st_d = SLOT0;
            endcase
        end
    end

    always_comb begin
        slot = st_q;
    end

endmodule

// File: rtl/aud_chan_framer.sv
module aud_chan_framer #(
    parameter int DEPTH = 256,
    localparam int LANES = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg_fmt,
    input  logic [31:0] cfg_fifo,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_word,
    output logic [1:0]  out_slot,
    output logic        xfer_req
);

    localparam logic [16:0] DEPTH_L = 17'(DEPTH);

    logic [2:0]         wbytes;
    logic [1:0]         last_slot;
    logic [LANES*8-1:0] head;
    logic [CNT_W-1:0]   occ;
    logic [16:0]        occ_x;
    logic [16:0]        lim_req;
    logic [16:0]        lim_eff;
    logic               push;
    logic               pop;

    aud_fmt_decode u_dec (
        .fmt       (cfg_fmt),
        .wbytes    (wbytes),
        .last_slot (last_slot)
    );

    aud_byte_store #(.DEPTH(DEPTH), .TAPS(LANES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (in_byte),
        .pop       (pop),
        .pop_n     (wbytes),
        .head      (head),
        .occ       (occ)
    );

    aud_frame_fsm u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (pop),
        .last_slot (last_slot),
        .slot      (out_slot)
    );

    always_comb begin
        occ_x   = 17'(occ);
        lim_req = {1'b0, cfg_fifo[31:16]};
        lim_eff = (lim_req > DEPTH_L) ? DEPTH_L : lim_req;
    end

    assign in_ready  = (occ_x < lim_eff);
    assign xfer_req  = (occ_x <= {1'b0, cfg_fifo[15:0]});
    assign out_valid = (occ_x >= 17'(wbytes));
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign out_word[8*i +: 8] = (3'(i) < wbytes) ? head[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/aud_chan_framer_chk.sv
module aud_chan_framer_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_fmt,
    input logic [31:0]      cfg_fifo,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_word,
    input logic [1:0]       out_slot,
    input logic             xfer_req,
    input logic [CNT_W-1:0] occ
);

    // R5: a refused byte with no pop leaves the occupancy unchanged
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !(out_valid && out_ready)) |=> (occ == $past(occ)));

    // R8: a word waiting on the peripheral stays valid and unchanged
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (!$stable(cfg_fmt) || (out_valid && $stable(out_word))));

    // R3: the slot number moves only on an accepted word
    assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> $stable(out_slot));

    // R4: reserved frame codes give a single-slot frame
    assert_single_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (cfg_fmt[7:4] >= 4'd3)) |=> (!$stable(cfg_fmt) || (out_slot == 2'd0)));

    // R6: with no incoming byte the request cannot drop
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !in_valid) |=> (xfer_req || !$stable(cfg_fifo)));

endmodule

bind aud_chan_framer aud_chan_framer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_fmt   (cfg_fmt),
    .cfg_fifo  (cfg_fifo),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_slot  (out_slot),
    .xfer_req  (xfer_req),
    .occ       (occ)
);

// File: tb/sim_aud_chan_framer.sv
module sim_aud_chan_framer;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_fmt = 8'h00;
    logic [31:0] cfg_fifo = 32'h00C0_0060;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic [1:0]  out_slot;
    logic        xfer_req;

    aud_chan_framer u0 (
        .clk (clk), .rst_n (rst_n), .cfg_fmt (cfg_fmt), .cfg_fifo (cfg_fifo),
        .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
        .out_valid (out_valid), .out_ready (out_ready), .out_word (out_word),
        .out_slot (out_slot), .xfer_req (xfer_req)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [31:0] w;
        logic [1:0]  s;
    } item_t;

    item_t       exp_q[$];
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    int          wb_cfg = 1;
    int          fw_cfg = 1;
    logic [31:0] acc = '0;
    int          acc_n = 0;
    int          slot_cnt = 0;
    int          ready_mode = 0;
    int          rdy_cnt = 0;
    string       cur_req = "R7";
    bit          hold_pend = 1'b0;
    logic [31:0] hold_word = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // scoreboard driver side: assemble expected words from accepted bytes
    task automatic note_byte(input logic [7:0] b);
        acc = acc | (32'(b) << (8 * acc_n));
        acc_n++;
        if (acc_n == wb_cfg) begin
            exp_q.push_back({acc, 2'(slot_cnt)});
            slot_cnt = (slot_cnt + 1) % fw_cfg;
            acc = '0;
            acc_n = 0;
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        note_byte(b);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic configure(input logic [7:0] f, input logic [31:0] c,
                             input int wb, input int fw);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        cfg_fmt  = f;
        cfg_fifo = c;
        wb_cfg   = wb;
        fw_cfg   = fw;
        acc      = '0;
        acc_n    = 0;
        slot_cnt = 0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain(input string req);
        ready_mode = 0;
        idle(24);
        #1;
        check(exp_q.size() == 0, req, "words left undelivered", 32'(exp_q.size()), 32'd0);
        check(out_valid == 1'b0, req, "out_valid after drain", 32'(out_valid), 32'd0);
    endtask

    // consumer ready pattern
    always @(negedge clk) begin
        rdy_cnt++;
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (rdy_cnt % 2) == 0;
            default: out_ready = 1'b0;
        endcase
    end

    // scoreboard monitor side
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (!rst_n) begin
                hold_pend = 1'b0;
            end else begin
                if (hold_pend && out_valid) begin
                    check(out_word == hold_word, "R8", "held word changed", out_word, hold_word);
                end else if (hold_pend) begin
                    check(1'b0, "R8", "valid dropped while held", 32'(out_valid), 32'd1);
                end
                hold_pend = out_valid && !out_ready;
                hold_word = out_word;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7", "unexpected word", out_word, 32'd0);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        check(out_word == it.w, cur_req, "word value", out_word, it.w);
                        check(out_slot == it.s, "R3", "slot number", 32'(out_slot), 32'(it.s));
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n_acc;
        logic [7:0] nb;

        // R1: reset state
        ready_mode = 2;
        configure(8'h00, {16'd192, 16'd96}, 1, 1);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid at reset", 32'(out_valid), 32'd0);
        check(out_slot == 2'd0, "R1", "out_slot at reset", 32'(out_slot), 32'd0);
        check(xfer_req == 1'b1, "R1", "xfer_req at reset", 32'(xfer_req), 32'd1);
        check(in_ready == 1'b1, "R1", "in_ready at reset", 32'(in_ready), 32'd1);

        // R2 and R9: 8-bit words, 1-word frames, consumer always ready
        cur_req = "R2";
        ready_mode = 0;
        configure(8'h00, {16'd192, 16'd96}, 1, 1);
        for (int i = 0; i < 6; i++) push_byte(8'h11 + 8'(i));
        drain("R9");

        // R2 and R3: 16-bit words, 2-word frames, alternating ready
        ready_mode = 1;
        configure(8'h11, {16'd192, 16'd96}, 2, 2);
        for (int i = 0; i < 12; i++) push_byte(8'hA0 + 8'(i));
        idle(30);
        drain("R3");

        // R2 and R3: 32-bit words, 4-word frames, slot wraps after the fourth word
        ready_mode = 1;
        configure(8'h22, {16'd192, 16'd96}, 4, 4);
        for (int i = 0; i < 20; i++) push_byte(8'h40 + 8'(3 * i));
        idle(30);
        drain("R3");

        // R4: reserved codes act as 32-bit words in 1-word frames
        cur_req = "R4";
        ready_mode = 0;
        configure(8'h3F, {16'd192, 16'd96}, 4, 1);
        for (int i = 0; i < 8; i++) push_byte(8'hC1 + 8'(i));
        drain("R4");

        // R5: limit of 8 bytes with the consumer stalled
        cur_req = "R5";
        ready_mode = 2;
        configure(8'h00, {16'd8, 16'd4}, 1, 1);
        n_acc = 0;
        nb = 8'h70;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = nb;
            #1;
            if (in_ready) begin
                note_byte(nb);
                n_acc++;
                nb++;
            end
        end
        check(n_acc == 8, "R5", "bytes accepted up to limit", 32'(n_acc), 32'd8);
        check(in_ready == 1'b0, "R5", "in_ready at limit", 32'(in_ready), 32'd0);
        check(xfer_req == 1'b0, "R6", "xfer_req above threshold", 32'(xfer_req), 32'd0);
        check(out_valid == 1'b1, "R7", "out_valid when full", 32'(out_valid), 32'd1);
        drain("R5");

        // R6: threshold of 3 bytes
        cur_req = "R6";
        ready_mode = 2;
        configure(8'h00, {16'd64, 16'd3}, 1, 1);
        for (int i = 0; i < 3; i++) push_byte(8'h20 + 8'(i));
        idle(1);
        #1;
        check(xfer_req == 1'b1, "R6", "xfer_req at threshold", 32'(xfer_req), 32'd1);
        push_byte(8'h23);
        idle(1);
        #1;
        check(xfer_req == 1'b0, "R6", "xfer_req one above threshold", 32'(xfer_req), 32'd0);
        drain("R6");
        check(xfer_req == 1'b1, "R6", "xfer_req after drain", 32'(xfer_req), 32'd1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule